// File: doc/BRIEF.md
# Processor Exception Entry and Return Sequencer

This block carries out the architectural state change that follows a single accepted exception. It is given the address of the next instruction, the present machine state word, an exception code and, for program exceptions, a subtype. On an entry strobe it stores a return address and a filtered copy of the machine state in one of two save pairs. It builds the handler's machine state from a few inherited bits and sends the program counter to the handler address, which it takes from a per-code vector table ORed with a base prefix.

The same block also performs the return from an interrupt. On a return strobe it reloads the program counter and machine state from the normal save pair, or from the critical save pair when the class input is set. A parameter selects between the classic model, which filters the saved and restored state, and the embedded model, which keeps the full state word. Entry and return each finish one clock after their strobe. A one-cycle completion pulse marks the finish. Codes with no handler, and table entries that are all ones, raise an error pulse and leave every register as it was.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the program counter, machine state, all four save registers, the completion pulse and the error pulse are zero.
- R2: In the classic model the saved state word is the incoming state with the bits under 0x783F0000 cleared. The register updates and `done_o` appear one clock after the strobe, and `done_o` lasts one cycle.
- R3: The handler machine state is zero apart from machine-check enable (bit 12), copied from the incoming state, and little-endian (bit 0), set when interrupt-little-endian (bit 16) was set.
- R4: Machine check (code 2) and system reset (code 1) clear bit 12 in the handler state. A reset taken while power-save (bit 18) is set also ORs 0x00010000 into the saved state.
- R5: Program exceptions (code 5) OR a reason bit into the saved state, chosen by `ent_kind_i`: floating-point (0) gives 0x00100000, illegal (1) gives 0x00080000, privileged (2) gives 0x00040000 and trap (3) gives 0x00020000. A floating-point program exception with FE0 (bit 11) different from FE1 (bit 8) also sets 0x00010000.
- R6: A floating-point program exception is dropped when FE0 and FE1 are both zero or when FP enable (bit 13) is zero. When it is dropped, no register changes and neither pulse fires.
- R7: Program (5), FP-unavailable (6), auxiliary-unavailable (7), vector-unavailable (8) and facility-unavailable (9) save the next address minus 4. Every other implemented code saves the next address unchanged.
- R8: The handler address is the table entry for the code ORed with the prefix. An entry of all ones raises `err_o` for one cycle and changes no register.
- R9: Codes 0 and 15 are unimplemented. They raise `err_o` and change no register.
- R10: With `ent_crit_i` set, an entry writes the critical save pair and leaves the normal pair unchanged. With it clear, the entry writes the normal pair and leaves the critical pair unchanged.
- R11: A normal return loads the program counter from the normal saved address with its two low bits cleared. It loads the machine state from the normal saved state with the 0x783F0000 bits cleared, or unfiltered in the embedded model.
- R12: A critical return loads the program counter from the critical saved address with its two low bits cleared, and the machine state from the critical saved state with its upper 16 bits cleared.
- R13: When an entry and a return are strobed in the same cycle, the entry is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_vld_i | input | 1 | Entry strobe |
| ent_code_i | input | 4 | Exception code |
| ent_kind_i | input | 2 | Program exception subtype |
| ent_crit_i | input | 1 | Selects the critical save pair for an entry |
| nia_i | input | AW | Address of the next instruction |
| msr_i | input | 32 | Present machine state word |
| vec_tbl_i | input | 16*AW | Handler offsets, entry n at bits n*AW and up |
| vec_prefix_i | input | AW | Vector base prefix |
| ret_vld_i | input | 1 | Return strobe |
| ret_crit_i | input | 1 | Selects the critical save pair for a return |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse |
| pc_o | output | AW | Redirected program counter |
| msr_o | output | 32 | New machine state |
| srr0_o | output | AW | Normal saved address |
| srr1_o | output | 32 | Normal saved state |
| csrr0_o | output | AW | Critical saved address |
| csrr1_o | output | 32 | Critical saved state |

## Verification
An entry strobe and a return strobe can arrive in the same cycle. Both would write the program counter and the machine state. The bench provokes this by raising both strobes on one clock edge after the save pair has been loaded with known values. The outcome counts as correct only if the program counter holds the entry's handler address, the machine state holds the handler state, and the save pair holds the new entry's return address rather than the values the return would have restored.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   localparam int CODE_W = 4;
   localparam int NCODE  = 1 << CODE_W;
   localparam int MW     = 32;

   typedef enum logic [CODE_W-1:0] {
      EXC_NONE  = 4'd0,
      EXC_RESET = 4'd1,
      EXC_MCHK  = 4'd2,
      EXC_CRIT  = 4'd3,
      EXC_EXT   = 4'd4,
      EXC_PROG  = 4'd5,
      EXC_FPU   = 4'd6,
      EXC_AUX   = 4'd7,
      EXC_VEC   = 4'd8,
      EXC_FAC   = 4'd9,
      EXC_DEC   = 4'd10,
      EXC_SC    = 4'd11,
      EXC_DSTOR = 4'd12,
      EXC_ISTOR = 4'd13,
      EXC_ALIGN = 4'd14,
      EXC_RSVD  = 4'd15
   } exc_code_e;

   typedef enum logic [1:0] {
      PRG_FP   = 2'd0,
      PRG_ILL  = 2'd1,
      PRG_PRIV = 2'd2,
      PRG_TRAP = 2'd3
   } prg_kind_e;

   localparam int B_LE  = 0;
   localparam int B_FE1 = 8;
   localparam int B_FE0 = 11;
   localparam int B_ME  = 12;
   localparam int B_FP  = 13;
   localparam int B_ILE = 16;
   localparam int B_POW = 18;

   localparam logic [MW-1:0] SAVE_CLR   = 32'h783F_0000;
   localparam logic [MW-1:0] CRIT_KEEP  = 32'h0000_FFFF;
   localparam logic [MW-1:0] RB_FP      = 32'h0010_0000;
   localparam logic [MW-1:0] RB_ILL     = 32'h0008_0000;
   localparam logic [MW-1:0] RB_PRIV    = 32'h0004_0000;
   localparam logic [MW-1:0] RB_TRAP    = 32'h0002_0000;
   localparam logic [MW-1:0] RB_FPSPLIT = 32'h0001_0000;
   localparam logic [MW-1:0] RB_WAKE    = 32'h0001_0000;

   typedef struct packed {
      logic known;
      logic save_cur;
      logic drop_me;
      logic is_prog;
      logic is_reset;
   } exc_class_t;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_seq_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output exc_class_t        cls_o
);
   exc_code_e code;

   always_comb begin
      code  = exc_code_e'(code_i);
      cls_o = '0;
      unique case (code)
         EXC_NONE, EXC_RSVD: cls_o.known = 1'b0;
         EXC_RESET: begin
            cls_o.known    = 1'b1;
            cls_o.drop_me  = 1'b1;
            cls_o.is_reset = 1'b1;
         end
         EXC_MCHK: begin
            cls_o.known   = 1'b1;
            cls_o.drop_me = 1'b1;
         end
         EXC_PROG: begin
            cls_o.known    = 1'b1;
            cls_o.save_cur = 1'b1;
            cls_o.is_prog  = 1'b1;
         end
         EXC_FPU, EXC_AUX, EXC_VEC, EXC_FAC: begin
            cls_o.known    = 1'b1;
            cls_o.save_cur = 1'b1;
         end
         default: cls_o.known = 1'b1;
      endcase
   end
endmodule

// File: rtl/exc_state_save.sv
module exc_state_save
   import exc_seq_pkg::*;
#(
   parameter bit EMBEDDED = 1'b0
)(
   input  logic [MW-1:0] msr_i,
   input  exc_class_t    cls_i,
   input  logic [1:0]    kind_i,
   output logic [MW-1:0] saved_o,
   output logic          drop_o
);
   logic [MW-1:0] base;
   logic [MW-1:0] reason;
   logic          fe0, fe1, fp_on;
   prg_kind_e     kind;

   generate
      if (EMBEDDED) begin : g_full
         assign base = msr_i;
      end else begin : g_filtered
         assign base = msr_i & ~SAVE_CLR;
      end
   endgenerate

   assign fe0   = msr_i[B_FE0];
   assign fe1   = msr_i[B_FE1];
   assign fp_on = msr_i[B_FP];

   always_comb begin
      kind   = prg_kind_e'(kind_i);
      reason = '0;
      drop_o = 1'b0;
      if (cls_i.is_prog) begin
         unique case (kind)
            PRG_FP: begin
               drop_o = (!fe0 && !fe1) || !fp_on;
               reason = RB_FP | ((fe0 != fe1) ? RB_FPSPLIT : '0);
            end
            PRG_ILL:  reason = RB_ILL;
            PRG_PRIV: reason = RB_PRIV;
            default:  reason = RB_TRAP;
         endcase
      end
      if (cls_i.is_reset && msr_i[B_POW]) begin
         reason = RB_WAKE;
      end
   end

   assign saved_o = base | reason;
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
   import exc_seq_pkg::*;
#(
   parameter int AW = 32
)(
   input  logic [NCODE*AW-1:0] vec_tbl_i,
   input  logic [AW-1:0]       prefix_i,
   input  logic [CODE_W-1:0]   code_i,
   input  logic [MW-1:0]       msr_i,
   input  exc_class_t          cls_i,
   output logic [AW-1:0]       hpc_o,
   output logic [MW-1:0]       hmsr_o,
   output logic                undef_o
);
   logic [AW-1:0] entry [NCODE];

   genvar gi;
   generate
      for (gi = 0; gi < NCODE; gi++) begin : g_slice
         assign entry[gi] = vec_tbl_i[gi*AW +: AW];
      end
   endgenerate

   logic [AW-1:0] sel;
   assign sel     = entry[code_i];
   assign undef_o = &sel;
   assign hpc_o   = sel | prefix_i;

   always_comb begin
      hmsr_o        = '0;
      hmsr_o[B_ME]  = msr_i[B_ME] & ~cls_i.drop_me;
      hmsr_o[B_LE]  = msr_i[B_ILE];
   end
endmodule

// File: rtl/exc_return_calc.sv
module exc_return_calc
   import exc_seq_pkg::*;
#(
   parameter int AW       = 32,
   parameter bit EMBEDDED = 1'b0
)(
   input  logic          crit_i,
   input  logic [AW-1:0] srr0_i,
   input  logic [MW-1:0] srr1_i,
   input  logic [AW-1:0] csrr0_i,
   input  logic [MW-1:0] csrr1_i,
   output logic [AW-1:0] pc_o,
   output logic [MW-1:0] msr_o
);
   localparam logic [AW-1:0] ALIGN_CLR = AW'(3);
   logic [MW-1:0] norm_keep;

   generate
      if (EMBEDDED) begin : g_keep_all
         assign norm_keep = '1;
      end else begin : g_keep_some
         assign norm_keep = ~SAVE_CLR;
      end
   endgenerate

   always_comb begin
      if (crit_i) begin
         pc_o  = csrr0_i & ~ALIGN_CLR;
         msr_o = csrr1_i & CRIT_KEEP;
      end else begin
         pc_o  = srr0_i & ~ALIGN_CLR;
         msr_o = srr1_i & norm_keep;
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int AW       = 32,
   parameter bit EMBEDDED = 1'b0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ent_vld_i,
   input  logic [3:0]          ent_code_i,
   input  logic [1:0]          ent_kind_i,
   input  logic                ent_crit_i,
   input  logic [AW-1:0]       nia_i,
   input  logic [31:0]         msr_i,
   input  logic [16*AW-1:0]    vec_tbl_i,
   input  logic [AW-1:0]       vec_prefix_i,
   input  logic                ret_vld_i,
   input  logic                ret_crit_i,
   output logic                done_o,
   output logic                err_o,
   output logic [AW-1:0]       pc_o,
   output logic [31:0]         msr_o,
   output logic [AW-1:0]       srr0_o,
   output logic [31:0]         srr1_o,
   output logic [AW-1:0]       csrr0_o,
   output logic [31:0]         csrr1_o
);
   localparam int NPAIR = 2;
   localparam logic [AW-1:0] INSN_BYTES = AW'(4);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("exc_entry_seq: AW must be at least 8");
      end
      if (CODE_W != 4 || MW != 32) begin : g_bad_pkg
         $error("exc_entry_seq: package widths do not match the port list");
      end
   endgenerate

   exc_class_t    cls;
   logic [MW-1:0] saved_msr;
   logic          fp_drop;
   logic [AW-1:0] hpc;
   logic [MW-1:0] hmsr;
   logic          vec_undef;
   logic [AW-1:0] rpc;
   logic [MW-1:0] rmsr;
   logic [AW-1:0] save_addr;
   logic          ent_take, ent_bad, ret_take;

   logic [AW-1:0] pair_addr [NPAIR];
   logic [MW-1:0] pair_msr  [NPAIR];

   exc_classify u_cls (
      .code_i (ent_code_i),
      .cls_o  (cls)
   );

   exc_state_save #(.EMBEDDED(EMBEDDED)) u_save (
      .msr_i   (msr_i),
      .cls_i   (cls),
      .kind_i  (ent_kind_i),
      .saved_o (saved_msr),
      .drop_o  (fp_drop)
   );

   exc_target_calc #(.AW(AW)) u_tgt (
      .vec_tbl_i (vec_tbl_i),
      .prefix_i  (vec_prefix_i),
      .code_i    (ent_code_i),
      .msr_i     (msr_i),
      .cls_i     (cls),
      .hpc_o     (hpc),
      .hmsr_o    (hmsr),
      .undef_o   (vec_undef)
   );

   exc_return_calc #(.AW(AW), .EMBEDDED(EMBEDDED)) u_ret (
      .crit_i  (ret_crit_i),
      .srr0_i  (pair_addr[0]),
      .srr1_i  (pair_msr[0]),
      .csrr0_i (pair_addr[1]),
      .csrr1_i (pair_msr[1]),
      .pc_o    (rpc),
      .msr_o   (rmsr)
   );

   assign save_addr = cls.save_cur ? (nia_i - INSN_BYTES) : nia_i;
   assign ent_bad   = ent_vld_i && !fp_drop && (!cls.known || vec_undef);
   assign ent_take  = ent_vld_i && !fp_drop && cls.known && !vec_undef;
   assign ret_take  = ret_vld_i && !ent_vld_i;

   genvar gp;
   generate
      for (gp = 0; gp < NPAIR; gp++) begin : g_pair
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pair_addr[gp] <= '0;
               pair_msr[gp]  <= '0;
            end else if (ent_take && (ent_crit_i == gp[0])) begin
               pair_addr[gp] <= save_addr;
               pair_msr[gp]  <= saved_msr;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         pc_o   <= '0;
         msr_o  <= '0;
      end else begin
         done_o <= ent_take || ret_take;
         err_o  <= ent_bad;
         if (ent_take) begin
            pc_o  <= hpc;
            msr_o <= hmsr;
         end else if (ret_take) begin
            pc_o  <= rpc;
            msr_o <= rmsr;
         end
      end
   end

   assign srr0_o  = pair_addr[0];
   assign srr1_o  = pair_msr[0];
   assign csrr0_o = pair_addr[1];
   assign csrr1_o = pair_msr[1];
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int AW = 32
)(
   input logic          clk,
   input logic          rst_n,
   input logic          ent_vld_i,
   input logic [3:0]    ent_code_i,
   input logic          ent_crit_i,
   input logic [31:0]   msr_i,
   input logic          ret_vld_i,
   input logic          ret_crit_i,
   input logic          done_o,
   input logic          err_o,
   input logic [AW-1:0] pc_o,
   input logic [31:0]   msr_o,
   input logic [AW-1:0] srr0_o,
   input logic [31:0]   srr1_o,
   input logic [AW-1:0] csrr0_o,
   input logic [31:0]   csrr1_o
);
   // R8
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R2
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ent_vld_i && !ret_vld_i) |=> !done_o);

   // R11
   ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld_i && !ent_vld_i) |=> (done_o && pc_o[1:0] == 2'b00));

   // R12
   ret_crit_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld_i && ret_crit_i && !ent_vld_i) |=> (msr_o[31:16] == 16'h0));

   // R4
   reset_me_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld_i && (ent_code_i == 4'd1 || ent_code_i == 4'd2)) |=> (!done_o || !msr_o[12]));

   // R3
   ile_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld_i && msr_i[16]) |=> (!done_o || msr_o[0]));

   // R9
   unimpl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld_i && (ent_code_i == 4'd0 || ent_code_i == 4'd15)) |=> (err_o && $stable(pc_o)));

   // R10
   pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld_i && ent_crit_i) |=> ($stable(srr0_o) && $stable(srr1_o)));

   // R11
   ret_keeps_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld_i && !ent_vld_i) |=> ($stable(srr0_o) && $stable(csrr0_o) && $stable(csrr1_o)));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ent_vld_i  (ent_vld_i),
   .ent_code_i (ent_code_i),
   .ent_crit_i (ent_crit_i),
   .msr_i      (msr_i),
   .ret_vld_i  (ret_vld_i),
   .ret_crit_i (ret_crit_i),
   .done_o     (done_o),
   .err_o      (err_o),
   .pc_o       (pc_o),
   .msr_o      (msr_o),
   .srr0_o     (srr0_o),
   .srr1_o     (srr1_o),
   .csrr0_o    (csrr0_o),
   .csrr1_o    (csrr1_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam logic [31:0] PREFIX = 32'hFFF0_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ent_vld = 1'b0;
   logic [3:0]    ent_code = '0;
   logic [1:0]    ent_kind = '0;
   logic          ent_crit = 1'b0;
   logic [31:0]   nia = '0;
   logic [31:0]   msr = '0;
   logic [16*AW-1:0] vec_tbl;
   logic          ret_vld = 1'b0;
   logic          ret_crit = 1'b0;
   logic          done, err;
   logic [31:0]   pc_o, msr_o, srr0, srr1, csrr0, csrr1;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_seq #(.AW(AW), .EMBEDDED(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ent_vld_i(ent_vld), .ent_code_i(ent_code), .ent_kind_i(ent_kind),
      .ent_crit_i(ent_crit), .nia_i(nia), .msr_i(msr),
      .vec_tbl_i(vec_tbl), .vec_prefix_i(PREFIX),
      .ret_vld_i(ret_vld), .ret_crit_i(ret_crit),
      .done_o(done), .err_o(err), .pc_o(pc_o), .msr_o(msr_o),
      .srr0_o(srr0), .srr1_o(srr1), .csrr0_o(csrr0), .csrr1_o(csrr1)
   );

   initial begin
      for (int i = 0; i < 16; i++) vec_tbl[i*AW +: AW] = 32'h100 * i;
      vec_tbl[10*AW +: AW] = '1;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic fire_entry(input logic [3:0] code, input logic [1:0] kind,
                             input logic crit, input logic [31:0] a, input logic [31:0] m);
      @(negedge clk);
      ent_code = code; ent_kind = kind; ent_crit = crit; nia = a; msr = m;
      ent_vld = 1'b1;
      @(negedge clk);
      ent_vld = 1'b0;
   endtask

   task automatic fire_return(input logic crit);
      @(negedge clk);
      ret_crit = crit; ret_vld = 1'b1;
      @(negedge clk);
      ret_vld = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 pc", pc_o, 0);      chk("R1 msr", msr_o, 0);
      chk("R1 srr0", srr0, 0);    chk("R1 srr1", srr1, 0);
      chk("R1 csrr0", csrr0, 0);  chk("R1 csrr1", csrr1, 0);
      chk("R1 done", {31'b0, done}, 0); chk("R1 err", {31'b0, err}, 0);
   endtask

   task automatic t_mask_and_handler;
      fire_entry(4'd4, 2'd0, 1'b0, 32'h2000_0010, 32'hFFFF_FFFF);
      chk("R2 done", {31'b0, done}, 1);
      chk("R2 srr1", srr1, 32'h87C0_FFFF);
      chk("R7 srr0 next", srr0, 32'h2000_0010);
      chk("R8 pc", pc_o, 32'hFFF0_0400);
      chk("R3 msr", msr_o, 32'h0000_1001);
      @(negedge clk);
      chk("R2 done pulse", {31'b0, done}, 0);
      fire_entry(4'd12, 2'd0, 1'b0, 32'h10, 32'h0000_0000);
      chk("R3 msr zero", msr_o, 32'h0);
   endtask

   task automatic t_me_clear;
      fire_entry(4'd2, 2'd0, 1'b0, 32'h100, 32'h0001_1000);
      chk("R4 mchk msr", msr_o, 32'h1);
      chk("R4 mchk pc", pc_o, 32'hFFF0_0200);
      fire_entry(4'd1, 2'd0, 1'b0, 32'h100, 32'h0004_1000);
      chk("R4 reset pow srr1", srr1, 32'h0001_1000);
      chk("R4 reset msr", msr_o, 32'h0);
      fire_entry(4'd1, 2'd0, 1'b0, 32'h100, 32'h0000_1000);
      chk("R4 reset awake srr1", srr1, 32'h0000_1000);
   endtask

   task automatic t_program;
      fire_entry(4'd5, 2'd0, 1'b0, 32'h3000, 32'h0000_2800);
      chk("R5 fp split srr1", srr1, 32'h0011_2800);
      chk("R7 prog srr0", srr0, 32'h2FFC);
      chk("R8 prog pc", pc_o, 32'hFFF0_0500);
      fire_entry(4'd5, 2'd0, 1'b0, 32'h3000, 32'h0000_2900);
      chk("R5 fp same srr1", srr1, 32'h0010_2900);
      fire_entry(4'd5, 2'd1, 1'b0, 32'h3000, 32'h0);
      chk("R5 ill srr1", srr1, 32'h0008_0000);
      fire_entry(4'd5, 2'd2, 1'b0, 32'h3000, 32'h0);
      chk("R5 priv srr1", srr1, 32'h0004_0000);
      fire_entry(4'd5, 2'd3, 1'b0, 32'h3000, 32'h0);
      chk("R5 trap srr1", srr1, 32'h0002_0000);
   endtask

   task automatic t_fp_drop;
      fire_entry(4'd11, 2'd0, 1'b0, 32'h0000_0A00, 32'h0000_1000);
      fire_entry(4'd5, 2'd0, 1'b0, 32'h9999_0000, 32'h0000_2000);
      chk("R6 no done", {31'b0, done}, 0);
      chk("R6 no err", {31'b0, err}, 0);
      chk("R6 srr0 kept", srr0, 32'h0000_0A00);
      chk("R6 pc kept", pc_o, 32'hFFF0_0B00);
      fire_entry(4'd5, 2'd0, 1'b0, 32'h9999_0000, 32'h0000_0900);
      chk("R6 fp off srr1 kept", srr1, 32'h0000_1000);
      chk("R6 fp off msr kept", msr_o, 32'h0000_1000);
   endtask

   task automatic t_addr_kind;
      for (int c = 6; c <= 9; c++) begin
         fire_entry(4'(c), 2'd0, 1'b0, 32'h4000, 32'h0);
         chk("R7 unavail srr0", srr0, 32'h3FFC);
      end
      fire_entry(4'd11, 2'd0, 1'b0, 32'h4000, 32'h0);
      chk("R7 syscall srr0", srr0, 32'h4000);
   endtask

   task automatic t_errors;
      fire_entry(4'd10, 2'd0, 1'b0, 32'h5555_0000, 32'h1000);
      chk("R8 undef err", {31'b0, err}, 1);
      chk("R8 undef done", {31'b0, done}, 0);
      chk("R8 undef pc kept", pc_o, 32'hFFF0_0B00);
      chk("R8 undef srr0 kept", srr0, 32'h4000);
      fire_entry(4'd0, 2'd0, 1'b0, 32'h5555_0000, 32'h1000);
      chk("R9 code0 err", {31'b0, err}, 1);
      chk("R9 code0 srr0 kept", srr0, 32'h4000);
      fire_entry(4'd15, 2'd0, 1'b1, 32'h5555_0000, 32'h1000);
      chk("R9 code15 err", {31'b0, err}, 1);
      chk("R9 code15 csrr0 kept", csrr0, 32'h0);
   endtask

   task automatic t_crit_and_return;
      fire_entry(4'd3, 2'd0, 1'b1, 32'h7002, 32'hABCD_1234);
      chk("R10 csrr0", csrr0, 32'h7002);
      chk("R10 csrr1", csrr1, 32'h83C0_1234);
      chk("R10 srr0 kept", srr0, 32'h4000);
      fire_entry(4'd11, 2'd0, 1'b0, 32'h6003, 32'hFFFF_FFFF);
      chk("R10 csrr0 kept", csrr0, 32'h7002);
      fire_return(1'b0);
      chk("R11 done", {31'b0, done}, 1);
      chk("R11 pc", pc_o, 32'h6000);
      chk("R11 msr", msr_o, 32'h87C0_FFFF);
      fire_return(1'b1);
      chk("R12 pc", pc_o, 32'h7000);
      chk("R12 msr", msr_o, 32'h0000_1234);
   endtask

   task automatic t_collide;
      @(negedge clk);
      ent_code = 4'd4; ent_kind = 2'd0; ent_crit = 1'b0; nia = 32'h8000; msr = 32'h0;
      ent_vld = 1'b1; ret_vld = 1'b1; ret_crit = 1'b0;
      @(negedge clk);
      ent_vld = 1'b0; ret_vld = 1'b0;
      chk("R13 pc entry", pc_o, 32'hFFF0_0400);
      chk("R13 msr entry", msr_o, 32'h0);
      chk("R13 srr0 entry", srr0, 32'h8000);
      chk("R13 done", {31'b0, done}, 1);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_and_handler();
      t_me_clear();
      t_program();
      t_fp_drop();
      t_addr_kind();
      t_errors();
      t_crit_and_return();
      t_collide();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule